// File: doc/BRIEF.md
# Grouped Edge Port Interrupt Detector

This block watches a group of bit-programmable I/O pins, arranged as several narrow ports, and raises one shared interrupt request when any pin that is configured as an input makes a transition in the selected direction. Each pin has a direction bit. A set bit makes the pin an output, which takes it out of interrupt detection altogether. A single polarity bit selects whether falling or rising transitions are of interest.

After one pin has triggered, the detector is disarmed. It arms again only once every participating input has gone back to its idle level. The idle level is high when falling edges are selected and low when rising edges are selected. A second pin that changes while the first is still active therefore produces no request. The block also owns the pull-resistor controls: one enable bit and one up/down select bit shared by all pins. From these it drives per-pin pull-up and pull-down enables, only for pins that are inputs.

Pin samples pass through a two-flop synchronizer before edge detection. The interrupt request is a single-cycle pulse, and the surrounding interrupt controller latches it.

Top module: `port_edge_irq`

## Requirements
- R1: Direction bit 0 makes a pin an input that takes part in detection. Direction bit 1 makes it an output whose transitions neither raise a request nor hold off re-arming. `pin_oe[i]` equals the direction bit of pin i. A direction write with `dir_we` high and `dir_sel`=k loads `dir_wdata[j]` into the direction bit of pin k*PORT_W+j.
- R2: With the polarity bit (`ctl_wdata[0]`, stored on `ctl_we`) at 0, a high-to-low transition on a participating pin raises `irq_req`, provided the detector is armed.
- R3: With the polarity bit at 1, a low-to-high transition on a participating pin raises `irq_req`, provided the detector is armed.
- R4: Once a request has been raised, no further request occurs until all participating pins have been seen at the idle level together. The idle level is high in falling mode and low in rising mode. Qualifying edges in the meantime are ignored.
- R5: A pin change applied between clock edges shows on `irq_req` after the second following rising clock edge, and `irq_req` stays high for exactly one cycle.
- R6: With the pull-enable bit (`ctl_wdata[2]`) at 0, all pull enables are low. With it at 1, the pull-select bit (`ctl_wdata[1]`) at 1 drives `pull_up_en`, and at 0 drives `pull_dn_en`, for every input pin.
- R7: A pin whose direction bit is 1 never has a pull enable asserted.
- R8: Reset clears all direction bits (all pins are inputs), clears the control bits (falling mode, pulls off), holds `irq_req` low and leaves the detector disarmed until the idle condition is observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PORTS*PORT_W | Raw pin levels |
| dir_we | input | 1 | Direction register write strobe |
| dir_sel | input | SEL_W | Port index for the direction write |
| dir_wdata | input | PORT_W | Direction bits for the selected port |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | {pull enable, pull select, polarity} |
| pin_oe | output | NUM_PORTS*PORT_W | Output-driver enable per pin |
| pull_up_en | output | NUM_PORTS*PORT_W | Pull-up enable per pin |
| pull_dn_en | output | NUM_PORTS*PORT_W | Pull-down enable per pin |
| irq_req | output | 1 | Single-cycle interrupt request |

## Verification
The bench goes after a second pin falling while the first is still low. A detector that re-arms on each edge would pulse twice there. It toggles output-configured pins, which a design that ignored the direction bits would treat as triggers or as blockers of re-arming. It returns pins to idle one at a time to catch a design that re-arms as soon as any single pin is idle, and it switches polarity to catch idle-level checks that are wired for one mode only. Long random runs with mixed direction and control writes are compared cycle by cycle against a bench model of the two-stage latency. A design with one stage too many or too few would be off by a cycle on every pulse.

// File: rtl/pei_pkg.sv
package pei_pkg;
   // control register layout: bit 0 polarity, bit 1 pull select, bit 2 pull enable
   localparam int CTL_W = 3;

   typedef struct packed {
      logic pull_on;    // pull resistors enabled
      logic pull_up;    // 1: pull-up, 0: pull-down
      logic rise;       // 1: rising edges, 0: falling edges
   } ctl_t;

   localparam ctl_t CTL_RESET = '{pull_on: 1'b0, pull_up: 1'b0, rise: 1'b0};
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         initial $error("pei_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/pei_cfg.sv
module pei_cfg
   import pei_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int PORT_W    = 4,
   localparam int NPINS    = NUM_PORTS * PORT_W,
   localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_we,
   input  logic [SEL_W-1:0] dir_sel,
   input  logic [PORT_W-1:0] dir_wdata,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [NPINS-1:0] dir_q,
   output ctl_t             ctl_q
);
   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dir_q[p*PORT_W +: PORT_W] <= '0;
            else if (dir_we && (dir_sel == SEL_W'(p)))
               dir_q[p*PORT_W +: PORT_W] <= dir_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= CTL_RESET;
      else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
   end
endmodule

// File: rtl/pei_detect.sv
module pei_detect #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_s,     // synchronized pin levels
   input  logic [NPINS-1:0] dir_q,     // 1 = output, excluded
   input  logic             rise,
   output logic             irq_req,
   output logic             armed_q,
   output logic             idle_all
);
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] watch;
   logic [NPINS-1:0] hit;
   logic             any_hit;
   logic             armed_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   assign watch = ~dir_q;

   always_comb begin
      if (rise) begin
         hit      = pin_s & ~prev_q & watch;
         idle_all = ~|(pin_s & watch);
      end else begin
         hit      = ~pin_s & prev_q & watch;
         idle_all = &(pin_s | dir_q);
      end
   end

   assign any_hit = |hit;
   assign irq_req = armed_q & any_hit;

   always_comb begin
      armed_d = armed_q;
      if (irq_req)       armed_d = 1'b0;
      else if (idle_all) armed_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
   import pei_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int PORT_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NUM_PORTS * PORT_W,
   localparam int SEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              dir_we,
   input  logic [SEL_W-1:0]  dir_sel,
   input  logic [PORT_W-1:0] dir_wdata,
   input  logic              ctl_we,
   input  logic [2:0]        ctl_wdata,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pull_up_en,
   output logic [NPINS-1:0]  pull_dn_en,
   output logic              irq_req
);
   generate
      if (NUM_PORTS < 1 || PORT_W < 1) begin : g_bad_shape
         initial $error("port_edge_irq: NUM_PORTS and PORT_W must be positive");
      end
      if (CTL_W != 3) begin : g_bad_ctl
         initial $error("port_edge_irq: control width mismatch");
      end
   endgenerate

   logic [NPINS-1:0] dir_w;
   ctl_t             ctl_w;
   logic [NPINS-1:0] pin_s;
   logic             armed_w;
   logic             idle_w;

   pei_cfg #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .dir_we(dir_we), .dir_sel(dir_sel), .dir_wdata(dir_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .dir_q(dir_w), .ctl_q(ctl_w)
   );

   pei_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_s)
   );

   pei_detect #(.NPINS(NPINS)) det_i (
      .clk(clk), .rst_n(rst_n),
      .pin_s(pin_s), .dir_q(dir_w), .rise(ctl_w.rise),
      .irq_req(irq_req), .armed_q(armed_w), .idle_all(idle_w)
   );

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pull
         assign pull_up_en[i] = ctl_w.pull_on &  ctl_w.pull_up & ~dir_w[i];
         assign pull_dn_en[i] = ctl_w.pull_on & ~ctl_w.pull_up & ~dir_w[i];
      end
   endgenerate

   assign pin_oe = dir_w;
endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic             armed_q,
   input logic             idle_all,
   input logic             pull_on,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pull_up_en,
   input logic [NPINS-1:0] pull_dn_en
);
   // R5
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   // R4
   disarm_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !armed_q);

   // R4
   hold_off_until_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !idle_all) |=> !irq_req);

   // R7
   no_pull_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pull_up_en | pull_dn_en) & pin_oe) == '0);

   // R6
   pulls_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pull_on |-> ((pull_up_en | pull_dn_en) == '0));

   // R6
   pull_dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en & pull_dn_en) == '0);
endmodule

bind port_edge_irq port_edge_irq_chk #(.NPINS(NPINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
   .armed_q(armed_w), .idle_all(idle_w), .pull_on(ctl_w.pull_on),
   .pin_oe(pin_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
);

// File: tb/port_edge_irq_tb_top.sv
module port_edge_irq_tb_top;
   localparam int NP = 2;
   localparam int PW = 4;
   localparam int N  = NP * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '1;
   logic          dir_we = 1'b0;
   logic [0:0]    dir_sel = '0;
   logic [PW-1:0] dir_wdata = '0;
   logic          ctl_we = 1'b0;
   logic [2:0]    ctl_wdata = '0;
   logic [N-1:0]  pin_oe, pull_up_en, pull_dn_en;
   logic          irq_req;

   int errors = 0;
   int checks = 0;
   int irq_seen = 0;
   bit done = 0;

   always #4 clk = ~clk;

   port_edge_irq #(.NUM_PORTS(NP), .PORT_W(PW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .dir_we(dir_we), .dir_sel(dir_sel), .dir_wdata(dir_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .pin_oe(pin_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
      .irq_req(irq_req)
   );

   // bench model of the requirements: two sync stages plus a previous sample
   logic [N-1:0] m_h1 = '0, m_h2 = '0, m_h3 = '0;
   logic [N-1:0] m_dir = '0;
   logic [2:0]   m_ctl = '0;
   logic         m_armed = 1'b0;

   function automatic logic f_edge(logic [N-1:0] cur, logic [N-1:0] prv,
                                   logic [N-1:0] dir, logic rise);
      logic [N-1:0] w = ~dir;
      return rise ? |(cur & ~prv & w) : |(~cur & prv & w);
   endfunction

   function automatic logic f_idle(logic [N-1:0] cur, logic [N-1:0] dir, logic rise);
      logic [N-1:0] w = ~dir;
      return rise ? ~|(cur & w) : ((cur & w) == w);
   endfunction

   function automatic logic [N-1:0] f_pull(logic [2:0] ctl, logic [N-1:0] dir, logic up);
      if (!ctl[2] || (ctl[1] != up)) return '0;
      return ~dir;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(string tag_irq);
      logic exp_irq;
      exp_irq = m_armed & f_edge(m_h2, m_h3, m_dir, m_ctl[0]);
      chk(tag_irq, 32'(irq_req), 32'(exp_irq));
      chk("R1", 32'(pin_oe), 32'(m_dir));
      chk("R6", 32'(pull_up_en), 32'(f_pull(m_ctl, m_dir, 1'b1)));
      chk("R7", 32'(pull_dn_en), 32'(f_pull(m_ctl, m_dir, 1'b0)));
      if (irq_req) irq_seen++;
   endtask

   // advance the model over the next rising edge using the inputs now driven
   task automatic model_step();
      logic e, idl;
      if (!rst_n) begin
         m_h1 = '0; m_h2 = '0; m_h3 = '0; m_dir = '0; m_ctl = '0; m_armed = 1'b0;
         return;
      end
      e   = m_armed & f_edge(m_h2, m_h3, m_dir, m_ctl[0]);
      idl = f_idle(m_h2, m_dir, m_ctl[0]);
      if (e)        m_armed = 1'b0;
      else if (idl) m_armed = 1'b1;
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = pin_in;
      if (dir_we) m_dir[dir_sel*PW +: PW] = dir_wdata;
      if (ctl_we) m_ctl = ctl_wdata;
   endtask

   // one clock: check outputs, drive new inputs, advance model
   task automatic step(string tag, logic [N-1:0] pins);
      @(negedge clk);
      compare_all(tag);
      pin_in = pins;
      dir_we = 1'b0;
      ctl_we = 1'b0;
      model_step();
   endtask

   task automatic wr_dir(logic [0:0] sel, logic [PW-1:0] d, logic [N-1:0] pins);
      @(negedge clk);
      compare_all("R1");
      pin_in = pins; dir_we = 1'b1; dir_sel = sel; dir_wdata = d; ctl_we = 1'b0;
      model_step();
   endtask

   task automatic wr_ctl(logic [2:0] c, logic [N-1:0] pins);
      @(negedge clk);
      compare_all("R6");
      pin_in = pins; ctl_we = 1'b1; ctl_wdata = c; dir_we = 1'b0;
      model_step();
   endtask

   // directed pulse count over a window
   task automatic expect_pulses(string tag, logic [N-1:0] pins, int cyc, int exp);
      int cnt = 0;
      for (int k = 0; k < cyc; k++) begin
         step(tag, pins);
         if (irq_req) cnt++;
      end
      chk(tag, 32'(cnt), 32'(exp));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = 32'h5EED_0017;
      void'($urandom(seed));
      // R8: reset state held with idle-high pins
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8", 32'(irq_req), 32'd0);
         chk("R8", 32'(pin_oe), 32'd0);
         chk("R8", 32'(pull_up_en | pull_dn_en), 32'd0);
      end
      rst_n = 1'b1;
      model_step();
      expect_pulses("R8", 8'hFF, 5, 0);

      // R2 / R5: one falling edge, a single one-cycle pulse, two edges late
      @(negedge clk);
      compare_all("R2");
      pin_in = 8'hFE; model_step();
      step("R5", 8'hFE);
      chk("R5", 32'(irq_req), 32'd0);
      step("R5", 8'hFE);
      chk("R5", 32'(irq_req), 32'd1);
      expect_pulses("R5", 8'hFE, 4, 0);

      // R4: second pin falls while first still low -> ignored
      expect_pulses("R4", 8'hFC, 6, 0);
      // release one pin only -> still not armed
      expect_pulses("R4", 8'hFD, 4, 0);
      expect_pulses("R4", 8'hFC, 4, 0);
      // all idle, then a new fall -> one pulse
      expect_pulses("R4", 8'hFF, 4, 0);
      expect_pulses("R2", 8'h7F, 6, 1);
      expect_pulses("R4", 8'hFF, 4, 0);

      // R1: pin 3 as output; its toggles neither trigger nor block re-arm
      wr_dir(1'b0, 4'b1000, 8'hFF);
      expect_pulses("R1", 8'hF7, 6, 0);
      expect_pulses("R1", 8'hFF, 3, 0);
      expect_pulses("R1", 8'hF7, 3, 0);
      expect_pulses("R1", 8'hE7, 6, 1);
      // with pin 3 low (output) the others returning high re-arms
      expect_pulses("R1", 8'hF7, 4, 0);
      expect_pulses("R1", 8'hB7, 6, 1);
      wr_dir(1'b0, 4'b0000, 8'hFF);
      expect_pulses("R1", 8'hFF, 4, 0);

      // R3: rising mode, idle low
      wr_ctl(3'b001, 8'h00);
      expect_pulses("R3", 8'h00, 4, 0);
      expect_pulses("R3", 8'h10, 6, 1);
      expect_pulses("R4", 8'h30, 4, 0);
      expect_pulses("R4", 8'h20, 4, 0);
      expect_pulses("R4", 8'h00, 4, 0);
      expect_pulses("R3", 8'h80, 6, 1);
      expect_pulses("R3", 8'h00, 4, 0);

      // R6 / R7: pull combinations with a mixed direction map
      wr_dir(1'b1, 4'b0101, 8'h00);
      wr_ctl(3'b111, 8'h00);
      step("R6", 8'h00);
      chk("R6", 32'(pull_up_en), 32'h000000AF);
      chk("R7", 32'(pull_dn_en), 32'd0);
      wr_ctl(3'b101, 8'h00);
      step("R6", 8'h00);
      chk("R6", 32'(pull_dn_en), 32'h000000AF);
      wr_ctl(3'b011, 8'h00);
      step("R6", 8'h00);
      chk("R6", 32'(pull_up_en | pull_dn_en), 32'd0);

      // random phase against the model
      for (int k = 0; k < 4000; k++) begin
         logic [N-1:0] p;
         int r;
         p = pin_in;
         for (int b = 0; b < N; b++)
            if (($urandom() % 10) == 0) p[b] = ~p[b];
         r = $urandom() % 100;
         if (r < 2)      wr_dir(1'($urandom()), PW'($urandom() & $urandom()), p);
         else if (r < 4) wr_ctl(3'($urandom()), p);
         else            step((m_ctl[0]) ? "R3" : "R2", p);
      end
      chk("R4", 32'(irq_seen > 20), 32'd1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule